// File: doc/BRIEF.md
# I2C pin-to-transaction bridge

This block sits behind a pair of sampled I2C lines driven by a bus master and turns the pin activity into byte-level requests on a downstream target port. The block detects START and STOP conditions and collects each address or write byte serially. It hands the address, together with its direction flag, and every following write byte to the target. The accept or refuse answer from the target becomes the acknowledge bit that the block drives back onto the data line.

For read transfers the bridge fetches a byte from the target at the start of each byte slot and presents it on the data line, most significant bit first. It then samples the master's acknowledge. If the master declines, the target is told and the block stays passive until the next START. The data-line output is a wired-AND of the master's level and the block's own drive, so it can be used directly as the resolved bus level.

Both lines are resynchronised into the system clock. Every downstream request is a one-cycle pulse that the target answers combinationally in that same cycle, so the pin-side sequencer never stalls.

Top module: `i2c_pin_bridge`

## Requirements
- R1: After reset `sda_o` is 1 and none of the request pulses (`tgt_start_o`, `tgt_send_o`, `tgt_fetch_o`, `tgt_end_o`, `tgt_nack_o`) is asserted.
- R2: SDA falling while SCL stays high is a START: byte collection restarts from bit 7 and the address is marked not yet received.
- R3: SDA rising while SCL stays high is a STOP: `tgt_end_o` pulses once if an address was accepted earlier in the transfer, and the block goes idle. After a refusal or with no address, no end pulse follows.
- R4: The first byte after START is shifted in MSB first on SCL rising edges. On the ninth rising edge `tgt_start_o` pulses with `tgt_addr_o` = byte[7:1] and `tgt_rnw_o` = byte[0], where 1 means read.
- R5: In a write transfer each later byte is issued on its ninth rising edge as a `tgt_send_o` pulse, with the byte on `tgt_wdata_o`.
- R6: When the target answers an address or write byte with `tgt_refuse_i` = 0, `sda_o` is 0 while SCL is high in the acknowledge slot. With `tgt_refuse_i` = 1, `sda_o` stays high, `tgt_end_o` pulses in the same cycle, and the block goes idle.
- R7: In a read transfer `tgt_fetch_o` pulses on the first rising edge of each byte and the byte on `tgt_rdata_i` is latched. Its bits appear on `sda_o` MSB first, one per SCL high phase.
- R8: In the acknowledge slot of a read byte, a master SDA of 1 pulses `tgt_nack_o` and leaves the block passive. A master SDA of 0 makes the next byte slot fetch again.
- R9: While idle or after a master NACK, SCL edges raise no request and the block's drive stays high until the next START.
- R10: `sda_o` is the AND of the synchronised master SDA and the block's own drive, and that drive returns high on every SCL falling edge.
- R11: SDA changes while SCL is low cause no request and do not alter the byte shifted in; only the SDA level at the SCL rising edge counts.
- R12: A START inside an active transfer (repeated START) restarts address collection without a `tgt_end_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Master clock line level |
| sda_i | input | 1 | Master data line level |
| sda_o | output | 1 | Resolved data line level (master AND bridge drive) |
| tgt_start_o | output | 1 | Address request pulse |
| tgt_addr_o | output | BYTE_W-1 | Target address, valid with tgt_start_o |
| tgt_rnw_o | output | 1 | Direction flag, 1 = read, valid with tgt_start_o |
| tgt_send_o | output | 1 | Write byte request pulse |
| tgt_wdata_o | output | BYTE_W | Write byte, valid with tgt_send_o |
| tgt_fetch_o | output | 1 | Read byte request pulse |
| tgt_rdata_i | input | BYTE_W | Read byte, sampled while tgt_fetch_o is high |
| tgt_refuse_i | input | 1 | Same-cycle answer to start/send: 1 = refuse (NACK) |
| tgt_end_o | output | 1 | End-of-transfer pulse |
| tgt_nack_o | output | 1 | Master declined a read byte |

## Verification
The hardest state to reach from the pins is the passive state after a master NACK. In that state clock pulses must produce neither fetches nor drive, and only the following STOP may emit the end pulse. The bench reaches it by reading two bytes, declining the second one, and then clocking a full extra byte with the data line released. A scoreboard of expected target events confirms that nothing is requested. A repeated START is formed by raising SCL while the line is high, which shifts one stray bit into the collector before SDA falls. The scoreboard then confirms that the new address arrives with no end pulse in between.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;

   // Pin-side sequencer states
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,  // passive, waiting for START
      ST_WR     = 3'd1,  // shifting in address or write byte
      ST_ACKW   = 3'd2,  // acknowledge slot of an incoming byte
      ST_RD     = 3'd3,  // shifting out a read byte
      ST_ACKR   = 3'd4,  // master acknowledge slot of a read byte
      ST_NACKED = 3'd5   // master declined, passive until START
   } brg_state_e;

endpackage

// File: rtl/i2c_brg_sync.sv
module i2c_brg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   // Idle bus level is high, so every stage resets to 1
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= 1'b1;
            else         chain_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[g] <= 1'b1;
            else         chain_q[g] <= chain_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b1;
      else         last_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;
   assign fall_o  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/i2c_brg_fsm.sv
module i2c_brg_fsm
   import i2c_brg_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scl_lvl_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_lvl_i,
   input  logic              sda_rise_i,
   input  logic              sda_fall_i,
   output logic              drv_nxt_o,
   output logic              start_o,
   output logic [BYTE_W-2:0] addr_o,
   output logic              rnw_o,
   output logic              send_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              fetch_o,
   input  logic [BYTE_W-1:0] rdata_i,
   input  logic              refuse_i,
   output logic              end_o,
   output logic              nack_o,
   output logic              addr_valid_o,
   output logic              rnw_q_o
);

   localparam int                CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W - 1);

   brg_state_e        st_q, st_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [BYTE_W-1:0] sh_q, sh_n;
   logic              av_q, av_n;
   logic              rnw_q, rnw_n;
   logic              drv_q, drv_n;
   logic [BYTE_W-1:0] cur;
   logic              scl_was_hi;
   logic              start_c, stop_c;

   // SCL high both before and after this sample
   assign scl_was_hi = scl_lvl_i & ~scl_rise_i;
   assign start_c    = sda_fall_i & scl_was_hi;
   assign stop_c     = sda_rise_i & scl_was_hi;

   always_comb begin
      st_n    = st_q;
      cnt_n   = cnt_q;
      sh_n    = sh_q;
      av_n    = av_q;
      rnw_n   = rnw_q;
      drv_n   = drv_q;
      start_o = 1'b0;
      send_o  = 1'b0;
      fetch_o = 1'b0;
      end_o   = 1'b0;
      nack_o  = 1'b0;
      cur     = sh_q;
      if (start_c) begin
         st_n  = ST_WR;
         cnt_n = '0;
         av_n  = 1'b0;
         drv_n = 1'b1;
      end else if (stop_c) begin
         end_o = av_q;
         av_n  = 1'b0;
         st_n  = ST_IDLE;
         drv_n = 1'b1;
      end else if (scl_fall_i) begin
         drv_n = 1'b1;
      end else if (scl_rise_i) begin
         drv_n = 1'b1;
         unique case (st_q)
            ST_WR: begin
               sh_n  = {sh_q[BYTE_W-2:0], sda_lvl_i};
               cnt_n = cnt_q + 1'b1;
               if (cnt_q == LAST) st_n = ST_ACKW;
            end
            ST_ACKW: begin
               if (!av_q) begin
                  start_o = 1'b1;
                  av_n    = 1'b1;
                  rnw_n   = sh_q[0];
               end else begin
                  send_o  = 1'b1;
               end
               if (refuse_i) begin
                  end_o = 1'b1;
                  av_n  = 1'b0;
                  st_n  = ST_IDLE;
               end else begin
                  drv_n = 1'b0;
                  cnt_n = '0;
                  st_n  = (av_q ? rnw_q : sh_q[0]) ? ST_RD : ST_WR;
               end
            end
            ST_RD: begin
               if (cnt_q == '0) begin
                  fetch_o = 1'b1;
                  cur     = rdata_i;
               end
               drv_n = cur[BYTE_W-1];
               sh_n  = {cur[BYTE_W-2:0], 1'b0};
               cnt_n = cnt_q + 1'b1;
               if (cnt_q == LAST) st_n = ST_ACKR;
            end
            ST_ACKR: begin
               cnt_n = '0;
               if (sda_lvl_i) begin
                  nack_o = 1'b1;
                  st_n   = ST_NACKED;
               end else begin
                  st_n   = ST_RD;
               end
            end
            default: ;  // idle and declined: edges ignored
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sh_q  <= '0;
         av_q  <= 1'b0;
         rnw_q <= 1'b0;
         drv_q <= 1'b1;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         sh_q  <= sh_n;
         av_q  <= av_n;
         rnw_q <= rnw_n;
         drv_q <= drv_n;
      end
   end

   assign drv_nxt_o    = drv_n;
   assign addr_o       = sh_q[BYTE_W-1:1];
   assign rnw_o        = sh_q[0];
   assign wdata_o      = sh_q;
   assign addr_valid_o = av_q;
   assign rnw_q_o      = rnw_q;

endmodule

// File: rtl/i2c_brg_sdaout.sv
module i2c_brg_sdaout (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic drv_i,
   input  logic sda_lvl_i,
   output logic sda_o
);

   // Wired-AND of the master level and the bridge drive, held in a flop
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sda_o <= 1'b1;
      else         sda_o <= drv_i & sda_lvl_i;
   end

endmodule

// File: rtl/i2c_pin_bridge.sv
module i2c_pin_bridge #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              tgt_start_o,
   output logic [BYTE_W-2:0] tgt_addr_o,
   output logic              tgt_rnw_o,
   output logic              tgt_send_o,
   output logic [BYTE_W-1:0] tgt_wdata_o,
   output logic              tgt_fetch_o,
   input  logic [BYTE_W-1:0] tgt_rdata_i,
   input  logic              tgt_refuse_i,
   output logic              tgt_end_o,
   output logic              tgt_nack_o
);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("i2c_pin_bridge: BYTE_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_pin_bridge: SYNC_STAGES must be at least 2");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic drv_nxt;
   logic addr_valid, rnw_q;

   i2c_brg_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (scl_i),
      .level_o (scl_lvl),
      .rise_o  (scl_rise),
      .fall_o  (scl_fall)
   );

   i2c_brg_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (sda_i),
      .level_o (sda_lvl),
      .rise_o  (sda_rise),
      .fall_o  (sda_fall)
   );

   i2c_brg_fsm #(.BYTE_W(BYTE_W)) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .scl_lvl_i    (scl_lvl),
      .scl_rise_i   (scl_rise),
      .scl_fall_i   (scl_fall),
      .sda_lvl_i    (sda_lvl),
      .sda_rise_i   (sda_rise),
      .sda_fall_i   (sda_fall),
      .drv_nxt_o    (drv_nxt),
      .start_o      (tgt_start_o),
      .addr_o       (tgt_addr_o),
      .rnw_o        (tgt_rnw_o),
      .send_o       (tgt_send_o),
      .wdata_o      (tgt_wdata_o),
      .fetch_o      (tgt_fetch_o),
      .rdata_i      (tgt_rdata_i),
      .refuse_i     (tgt_refuse_i),
      .end_o        (tgt_end_o),
      .nack_o       (tgt_nack_o),
      .addr_valid_o (addr_valid),
      .rnw_q_o      (rnw_q)
   );

   i2c_brg_sdaout u_sdaout (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .drv_i     (drv_nxt),
      .sda_lvl_i (sda_lvl),
      .sda_o     (sda_o)
   );

endmodule

// File: rtl/i2c_brg_chk.sv
module i2c_brg_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic sda_lvl,
   input logic scl_fall,
   input logic sda_o,
   input logic start,
   input logic send,
   input logic fetch,
   input logic fin,
   input logic refuse,
   input logic addr_valid,
   input logic rnw_q
);

   AST_ONE_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({start, send, fetch}));                                   // R4

   AST_REFUSAL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((start || send) && refuse) |-> fin);                              // R6

   AST_END_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fin && !start) |-> addr_valid);                                   // R3

   AST_FETCH_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fetch |-> rnw_q);                                                  // R7

   AST_WIRED_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sda_lvl |=> !sda_o);                                              // R10

   AST_FALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scl_fall |=> (sda_o == $past(sda_lvl)));                           // R10

endmodule

bind i2c_pin_bridge i2c_brg_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sda_lvl    (sda_lvl),
   .scl_fall   (scl_fall),
   .sda_o      (sda_o),
   .start      (tgt_start_o),
   .send       (tgt_send_o),
   .fetch      (tgt_fetch_o),
   .fin        (tgt_end_o),
   .refuse     (tgt_refuse_i),
   .addr_valid (addr_valid),
   .rnw_q      (rnw_q)
);

// File: tb/i2c_pin_bridge_tb_top.sv
`timescale 1ns/1ps
module i2c_pin_bridge_tb_top;

   localparam int H = 10;  // clocks per bus phase
   localparam logic [2:0] K_START = 3'd1, K_SEND = 3'd2, K_FETCH = 3'd3,
                          K_END = 3'd4, K_NACK = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic sda_o;
   logic t_start, t_rnw, t_send, t_fetch, t_end, t_nack, t_refuse;
   logic [6:0] t_addr;
   logic [7:0] t_wdata, rd_data = 8'h00;

   int compared = 0, mismatched = 0;
   bit done = 0;
   logic [10:0] exp_q[$];

   always #10 clk = ~clk;  // 50 MHz

   i2c_pin_bridge dut_i (
      .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o),
      .tgt_start_o(t_start), .tgt_addr_o(t_addr), .tgt_rnw_o(t_rnw),
      .tgt_send_o(t_send), .tgt_wdata_o(t_wdata), .tgt_fetch_o(t_fetch),
      .tgt_rdata_i(rd_data), .tgt_refuse_i(t_refuse),
      .tgt_end_o(t_end), .tgt_nack_o(t_nack)
   );

   // Target model: only address 0x50 answers; data byte 0xFF is refused
   assign t_refuse = (t_start && t_addr != 7'h50) || (t_send && t_wdata == 8'hFF);

   task automatic chk(input bit ok, input string req, input logic [10:0] act,
                      input logic [10:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] k, input logic [7:0] d);
      exp_q.push_back({k, d});
   endtask

   task automatic mon(input logic [10:0] got, input string req);
      logic [10:0] e;
      if (exp_q.size() == 0) chk(1'b0, {req, " unexpected request"}, got, 11'h0);
      else begin
         e = exp_q.pop_front();
         chk(got == e, req, got, e);
      end
   endtask

   // Monitor: compare every target request with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (t_start) mon({K_START, t_addr, t_rnw}, "R4");
         if (t_send)  mon({K_SEND, t_wdata}, "R5");
         if (t_fetch) mon({K_FETCH, 8'h00}, "R7");
         if (t_end)   mon({K_END, 8'h00}, "R3");
         if (t_nack)  mon({K_NACK, 8'h00}, "R8");
      end
   end

   task automatic half();
      repeat (H) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic r);
      sda = b; half();
      scl = 1'b1; half();
      r = sda_o;
      scl = 1'b0; half();
   endtask

   task automatic start_c();
      sda = 1'b1; half();
      scl = 1'b1; half();
      sda = 1'b0; half();
      scl = 1'b0; half();
   endtask

   task automatic stop_c();
      sda = 1'b0; half();
      scl = 1'b1; half();
      sda = 1'b1; half();
   endtask

   task automatic write_byte(input logic [7:0] b, input bit ack, input string req);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(b[i], r);
         chk(r == b[i], "R10 data follows master", {10'h0, r}, {10'h0, b[i]});
      end
      clk_bit(1'b1, r);
      chk(r == !ack, req, {10'h0, r}, {10'h0, !ack});
   endtask

   task automatic read_byte(input logic [7:0] b, input bit mack);
      logic r;
      rd_data = b;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, r);
         chk(r == b[i], "R7 read bit", {10'h0, r}, {10'h0, b[i]});
      end
      clk_bit(!mack, r);
      chk(r == !mack, "R10 master ack level", {10'h0, r}, {10'h0, !mack});
   endtask

   task automatic drained(input string req);
      half();
      chk(exp_q.size() == 0, req, 11'(exp_q.size()), 11'h0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(sda_o == 1'b1, "R1 sda_o after reset", {10'h0, sda_o}, 11'h1);
      chk({t_start, t_send, t_fetch, t_end, t_nack} == 5'b0, "R1 no requests",
          {6'h0, t_start, t_send, t_fetch, t_end, t_nack}, 11'h0);

      // R2 R4 R5 R6 R11: write two bytes to 0x50
      push(K_START, 8'hA0); push(K_SEND, 8'h3C); push(K_SEND, 8'h81); push(K_END, 8'h00);
      start_c();
      write_byte(8'hA0, 1, "R6 address ack");
      for (int i = 0; i < 4; i++) begin  // R11: wiggle SDA with SCL low
         sda = i[0]; half();
         chk(sda_o == sda, "R11 low-phase sda passes", {10'h0, sda_o}, {10'h0, sda});
      end
      write_byte(8'h3C, 1, "R6 data ack");
      write_byte(8'h81, 1, "R6 data ack");
      stop_c();
      drained("R5 write sequence complete");

      // R6 R9 R3: absent address, following byte ignored, STOP silent
      push(K_START, 8'h42); push(K_END, 8'h00);
      start_c();
      write_byte(8'h42, 0, "R6 address refused");
      write_byte(8'h55, 0, "R9 idle clocks ignored");
      stop_c();
      drained("R3 no end without address");

      // R6: refused write byte ends transfer
      push(K_START, 8'hA0); push(K_SEND, 8'hFF); push(K_END, 8'h00);
      start_c();
      write_byte(8'hA0, 1, "R6 address ack");
      write_byte(8'hFF, 0, "R6 data refused");
      stop_c();
      drained("R6 refusal sequence");

      // R7 R8 R9: read two bytes, decline the second, then idle clocks
      push(K_START, 8'hA1); push(K_FETCH, 8'h00); push(K_FETCH, 8'h00);
      push(K_NACK, 8'h00); push(K_END, 8'h00);
      start_c();
      write_byte(8'hA1, 1, "R6 read address ack");
      read_byte(8'hA5, 1);
      read_byte(8'h3C, 0);
      for (int i = 0; i < 9; i++) begin
         logic r;
         clk_bit(1'b1, r);
         chk(r == 1'b1, "R9 declined state drives high", {10'h0, r}, 11'h1);
      end
      stop_c();
      drained("R8 read sequence");

      // R12 R2: repeated START switches to read without an end pulse
      push(K_START, 8'hA0); push(K_SEND, 8'h12); push(K_START, 8'hA1);
      push(K_FETCH, 8'h00); push(K_NACK, 8'h00); push(K_END, 8'h00);
      start_c();
      write_byte(8'hA0, 1, "R6 address ack");
      write_byte(8'h12, 1, "R6 data ack");
      start_c();
      write_byte(8'hA1, 1, "R12 address after repeated start");
      read_byte(8'hC3, 0);
      stop_c();
      drained("R12 repeated start sequence");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule